// File: doc/BRIEF.md
# Sparse-Map Register Responder

This block is an AXI4-Lite subordinate that sits in front of a sparse register map. It holds nine address regions: three 1 KiB windows near the bottom of the map (control, debug and performance monitoring), two 16-byte windows (interrupt status and time measurement), and four 4 KiB configuration windows, one for each function. Every region keeps a small local bank of words at its start. All other offsets in a region are reserved.

The response policy is fixed. Any access that lands inside a region completes with OKAY. Reserved offsets read as zero, and writes to them are discarded. Any access that falls outside every region completes with DECERR, returns zero data and changes nothing. Every implemented word has a per-bit writable mask, so a write updates only the writable bits and still answers OKAY. One control word carries a live hardware status field that software can only read.

Top module: `csr_region_responder`

## Requirements
- R1: After a synchronous active-low reset, BVALID and RVALID are low, AWREADY, WREADY and ARREADY are high, and every implemented writable bit reads as zero.
- R2: The block decodes nine regions, byte addresses inclusive: 0x00000–0x003FF, 0x00400–0x007FF, 0x00800–0x00BFF, 0x1414C–0x1415B, 0x141A0–0x141AF, 0x80000–0x80FFF, 0x81000–0x81FFF, 0x82000–0x82FFF and 0x83000–0x83FFF. The first four 32-bit words of each region (offsets 0x0, 0x4, 0x8 and 0xC from the region base) are implemented. Each region has its own storage, and accesses answer OKAY (code 2'b00).
- R3: Any other word inside a region is reserved. A read of it returns zero data with OKAY. A write to it returns OKAY and changes no register.
- R4: An address outside every region answers DECERR (code 2'b11). A read returns zero data, and a write changes no register.
- R5: Writable masks by word offset are: 0x0 all bits, 0x4 bits 15:0, 0x8 bits 23:16 and 7:0, 0xC all bits. Read-only bits read as zero, except word 0x4 of the control region at 0x00000, whose bits 31:16 show the live `status_in` input. A write that touches read-only bits answers OKAY and changes only the writable bits.
- R6: WSTRB bit n enables byte lane n (data bits 8n+7:8n). Disabled lanes keep their old value.
- R7: The write address and write data may arrive in either order or together. Exactly one B response follows once both have arrived, and none arrives before that.
- R8: Once raised, BVALID and RVALID stay high with BRESP, RRESP and RDATA stable until the matching ready is seen. They drop in the cycle after the handshake.
- R9: Only one write and one read may be outstanding. AWREADY and WREADY are low while BVALID is high, and ARREADY is low while RVALID is high.
- R10: Address bits 1:0 are ignored, so any byte address inside a word selects that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| status_in | input | 16 | Live hardware status, shown read-only in control word 0x4 bits 31:16 |
| awaddr | input | ADDR_W | Write address |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address ready |
| wdata | input | 32 | Write data |
| wstrb | input | 4 | Write byte strobes |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data ready |
| bresp | output | 2 | Write response code |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response ready |
| araddr | input | ADDR_W | Read address |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address ready |
| rdata | output | 32 | Read data |
| rresp | output | 2 | Read response code |
| rvalid | output | 1 | Read response valid |
| rready | input | 1 | Read response ready |

## Verification
The assertions watch every cycle for the channel discipline. They check that responses hold steady under back-pressure, that the ready signals stay low while a response is pending, that each response drops right after its handshake, that only the two legal codes appear, and that a DECERR read carries zero data. The bench scenarios are needed to show what the map means. These scenarios cover the region edges, the gap addresses just outside the small windows, reserved words reading zero, writable masks and byte strobes, the live status field, and the two orders in which a write's address and data can arrive. Each one is observed through a read-back after the write.

// File: rtl/csr_map_pkg.sv
// Package: region table, response codes and per-word writable masks shared
// by the decoder, the register banks and the top. Addresses are handled as
// 30-bit word indices (byte address >> 2). Regions must not overlap.
package csr_map_pkg;

    localparam int NUM_REGIONS   = 9;
    localparam int REGS_PER_BANK = 4;
    localparam int DATA_W        = 32;
    localparam int STRB_W        = DATA_W / 8;
    localparam int RGN_W         = $clog2(NUM_REGIONS);
    localparam int IDX_W         = $clog2(REGS_PER_BANK);

    localparam logic [1:0] RESP_OKAY   = 2'b00;
    localparam logic [1:0] RESP_DECERR = 2'b11;

    localparam int RGN_CTRL   = 0;
    localparam int STATUS_IDX = 1;

    typedef struct packed {
        logic             hit;
        logic             impl;
        logic [RGN_W-1:0] region;
        logic [IDX_W-1:0] idx;
    } decode_t;

    // First byte address of region r, returned as a word index.
    function automatic logic [29:0] region_first_w(input int r);
        logic [31:0] b;
        case (r)
            0:       b = 32'h0000_0000;
            1:       b = 32'h0000_0400;
            2:       b = 32'h0000_0800;
            3:       b = 32'h0001_414C;
            4:       b = 32'h0001_41A0;
            default: b = 32'h0008_0000 + 32'((r - 5) * 32'h1000);
        endcase
        return b[31:2];
    endfunction

    // Last word index of region r (inclusive).
    function automatic logic [29:0] region_last_w(input int r);
        logic [29:0] size_w;
        if (r < 3)       size_w = 30'h100;
        else if (r < 5)  size_w = 30'h4;
        else             size_w = 30'h400;
        return region_first_w(r) + size_w - 30'd1;
    endfunction

    // Writable bits of an implemented word, by word offset in its bank.
    function automatic logic [DATA_W-1:0] wmask_of(input logic [IDX_W-1:0] i);
        case (i)
            IDX_W'(1): return 32'h0000_FFFF;
            IDX_W'(2): return 32'h00FF_00FF;
            default:   return 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/csr_addr_decode.sv
// Address decoder: maps a byte address to region, hit, implemented flag and
// word index within the region's bank. Purely combinational.
// Assumes 20 <= ADDR_W <= 32 and non-overlapping regions; bits 1:0 ignored.
module csr_addr_decode
    import csr_map_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic [ADDR_W-1:0] addr,
    output decode_t           dec
);

    logic [29:0] a_w;
    logic [29:0] off_w;
    logic [1:0]  unused_lsb;

    assign unused_lsb = addr[1:0];

    // Search the region table for the word address.
    always_comb begin
        a_w              = '0;
        a_w[ADDR_W-3:0]  = addr[ADDR_W-1:2];
        off_w            = '0;
        dec              = '0;
        for (int r = 0; r < NUM_REGIONS; r++) begin
            if (a_w >= region_first_w(r) && a_w <= region_last_w(r)) begin
                dec.hit    = 1'b1;
                dec.region = RGN_W'(r);
                off_w      = a_w - region_first_w(r);
            end
        end
        dec.impl = dec.hit && (off_w < 30'(REGS_PER_BANK));
        dec.idx  = off_w[IDX_W-1:0];
    end

endmodule

// File: rtl/csr_reg_bank.sv
// Register bank: REGS_PER_BANK words with per-bit writable masks and byte
// strobes. Read-only bits are never stored, so they always read zero here;
// any live read-only field is overlaid by the caller. Assumes wr_idx is valid.
module csr_reg_bank
    import csr_map_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [STRB_W-1:0] wr_strb,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] regs [REGS_PER_BANK];
    logic [DATA_W-1:0] lane_m;
    logic [DATA_W-1:0] upd_m;

    // Expand strobes to a bit mask and keep only writable bits.
    always_comb begin
        for (int b = 0; b < STRB_W; b++) begin
            lane_m[8*b +: 8] = {8{wr_strb[b]}};
        end
        upd_m = lane_m & wmask_of(wr_idx);
    end

    // Store the selected bits of the addressed word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < REGS_PER_BANK; i++) begin
                regs[i] <= '0;
            end
        end else if (wr_en) begin
            regs[wr_idx] <= (regs[wr_idx] & ~upd_m) | (wr_data & upd_m);
        end
    end

    // Return the addressed word.
    assign rd_data = regs[rd_idx];

endmodule

// File: rtl/csr_region_responder.sv
// Top: AXI4-Lite subordinate over a sparse region map. Write address and
// data are captured independently, then committed together with one B
// response. Reads answer one cycle after the AR handshake. At most one
// response per direction is pending, and the ready signals are low while it is.
// Assumes 20 <= ADDR_W <= 32 and that no bursts or protection attributes are used.
module csr_region_responder
    import csr_map_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       status_in,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic              awvalid,
    output logic              awready,
    input  logic [DATA_W-1:0] wdata,
    input  logic [STRB_W-1:0] wstrb,
    input  logic              wvalid,
    output logic              wready,
    output logic [1:0]        bresp,
    output logic              bvalid,
    input  logic              bready,
    input  logic [ADDR_W-1:0] araddr,
    input  logic              arvalid,
    output logic              arready,
    output logic [DATA_W-1:0] rdata,
    output logic [1:0]        rresp,
    output logic              rvalid,
    input  logic              rready
);

    logic              aw_have, w_have;
    logic [ADDR_W-1:0] aw_q;
    logic [DATA_W-1:0] w_q;
    logic [STRB_W-1:0] strb_q;
    logic              wr_commit;
    decode_t           wdec, rdec;
    logic [DATA_W-1:0] bank_rd [NUM_REGIONS];
    logic [DATA_W-1:0] rd_word;

    csr_addr_decode #(.ADDR_W(ADDR_W)) u_wdec (.addr(aw_q),   .dec(wdec));
    csr_addr_decode #(.ADDR_W(ADDR_W)) u_rdec (.addr(araddr), .dec(rdec));

    assign awready   = !aw_have && !bvalid;
    assign wready    = !w_have && !bvalid;
    assign arready   = !rvalid;
    assign wr_commit = aw_have && w_have && !bvalid;

    // One bank per region; only an implemented hit in that region writes it.
    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_bank
        csr_reg_bank u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_commit && wdec.impl && (wdec.region == RGN_W'(g))),
            .wr_idx  (wdec.idx),
            .wr_data (w_q),
            .wr_strb (strb_q),
            .rd_idx  (rdec.idx),
            .rd_data (bank_rd[g])
        );
    end

    // Select the read word and overlay the live status field.
    always_comb begin
        rd_word = '0;
        if (rdec.impl) begin
            rd_word = bank_rd[rdec.region];
            if (rdec.region == RGN_W'(RGN_CTRL) && rdec.idx == IDX_W'(STATUS_IDX)) begin
                rd_word[31:16] = status_in;
            end
        end
    end

    // Write path: capture AW and W separately, commit, hold the B response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aw_have <= 1'b0;
            w_have  <= 1'b0;
            aw_q    <= '0;
            w_q     <= '0;
            strb_q  <= '0;
            bvalid  <= 1'b0;
            bresp   <= RESP_OKAY;
        end else begin
            if (awvalid && awready) begin
                aw_have <= 1'b1;
                aw_q    <= awaddr;
            end
            if (wvalid && wready) begin
                w_have <= 1'b1;
                w_q    <= wdata;
                strb_q <= wstrb;
            end
            if (wr_commit) begin
                aw_have <= 1'b0;
                w_have  <= 1'b0;
                bvalid  <= 1'b1;
                bresp   <= wdec.hit ? RESP_OKAY : RESP_DECERR;
            end else if (bvalid && bready) begin
                bvalid <= 1'b0;
            end
        end
    end

    // Read path: answer the accepted address and hold until taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rresp  <= RESP_OKAY;
            rdata  <= '0;
        end else if (arvalid && arready) begin
            rvalid <= 1'b1;
            rresp  <= rdec.hit ? RESP_OKAY : RESP_DECERR;
            rdata  <= rd_word;
        end else if (rvalid && rready) begin
            rvalid <= 1'b0;
        end
    end

endmodule

// File: rtl/csr_region_responder_chk.sv
// Checker: channel-level properties of the responder, bound to the top.
module csr_region_responder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        awready,
    input logic        wready,
    input logic        bvalid,
    input logic        bready,
    input logic [1:0]  bresp,
    input logic        arready,
    input logic        rvalid,
    input logic        rready,
    input logic [1:0]  rresp,
    input logic [31:0] rdata
);

    // R9
    wr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid |-> (!awready && !wready));

    // R9
    rd_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> !arready);

    // R8
    b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bvalid && !bready) |=> (bvalid && $stable(bresp)));

    // R8
    r_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && !rready) |=> (rvalid && $stable(rresp) && $stable(rdata)));

    // R7
    b_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bvalid && bready) |=> !bvalid);

    // R8
    r_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && rready) |=> !rvalid);

    // R4
    decerr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && rresp == 2'b11) |-> (rdata == 32'h0));

    // R2
    resp_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid |-> (bresp == 2'b00 || bresp == 2'b11));

endmodule

bind csr_region_responder csr_region_responder_chk u_chk (.*);

// File: tb/csr_region_responder_test.sv
// Directed bench: one task per scenario, each checking its own results.
module csr_region_responder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] status_in = 16'h0;
    logic [19:0] awaddr = '0, araddr = '0;
    logic        awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
    logic [31:0] wdata = '0;
    logic [3:0]  wstrb = '0;
    logic        awready, wready, bvalid, arready, rvalid;
    logic [1:0]  bresp, rresp;
    logic [31:0] rdata;

    int n_chk = 0, n_fail = 0, bcount = 0;

    always #10 clk = ~clk;

    csr_region_responder uut (.*);

    always @(posedge clk) if (rst_n && bvalid && bready) bcount++;

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // mode 0: AW and W together, 1: AW first, 2: W first. hold: cycles bready low.
    task automatic axi_write(input logic [19:0] a, input logic [31:0] d, input logic [3:0] s,
                             input int mode, input int hold, output logic [1:0] resp);
        logic [1:0] r0;
        if (mode != 2) begin awaddr = a; awvalid = 1; end
        if (mode != 1) begin wdata = d; wstrb = s; wvalid = 1; end
        @(negedge clk);
        awvalid = 0; wvalid = 0;
        if (mode != 0) begin
            repeat (2) @(negedge clk);
            check("R7 no response before both halves", {31'b0, bvalid}, 32'h0);
            if (mode == 1) begin wdata = d; wstrb = s; wvalid = 1; end
            else begin awaddr = a; awvalid = 1; end
            @(negedge clk);
            awvalid = 0; wvalid = 0;
        end
        while (!bvalid) @(negedge clk);
        r0 = bresp;
        for (int k = 0; k < hold; k++) begin
            @(negedge clk);
            check("R8 bvalid held", {31'b0, bvalid}, 32'h1);
            check("R8 bresp stable", {30'b0, bresp}, {30'b0, r0});
            check("R9 write readies low", {30'b0, awready, wready}, 32'h0);
        end
        resp = bresp;
        bready = 1;
        @(negedge clk);
        bready = 0;
    endtask

    task automatic axi_read(input logic [19:0] a, input int hold,
                            output logic [31:0] d, output logic [1:0] resp);
        logic [31:0] d0;
        araddr = a; arvalid = 1;
        @(negedge clk);
        arvalid = 0;
        while (!rvalid) @(negedge clk);
        d0 = rdata;
        for (int k = 0; k < hold; k++) begin
            @(negedge clk);
            check("R8 rvalid held", {31'b0, rvalid}, 32'h1);
            check("R8 rdata stable", rdata, d0);
            check("R9 arready low", {31'b0, arready}, 32'h0);
        end
        d = rdata; resp = rresp;
        rready = 1;
        @(negedge clk);
        rready = 0;
    endtask

    task automatic t_reset();
        logic [31:0] d; logic [1:0] r;
        check("R1 bvalid after reset", {31'b0, bvalid}, 32'h0);
        check("R1 rvalid after reset", {31'b0, rvalid}, 32'h0);
        check("R1 readies after reset", {29'b0, awready, wready, arready}, 32'h7);
        axi_read(20'h0_0000, 0, d, r);
        check("R1 control word 0 zero", d, 32'h0);
        axi_read(20'h8_300C, 0, d, r);
        check("R1 function 3 word 3 zero", d, 32'h0);
    endtask

    task automatic t_region_map();
        logic [19:0] bases [9] = '{20'h0_0000, 20'h0_0400, 20'h0_0800, 20'h1_414C, 20'h1_41A0,
                                    20'h8_0000, 20'h8_1000, 20'h8_2000, 20'h8_3000};
        logic [31:0] d; logic [1:0] r;
        for (int i = 0; i < 9; i++) begin
            axi_write(bases[i], 32'hA000_0000 + i, 4'hF, 0, 0, r);
            check("R2 write resp OKAY", {30'b0, r}, 32'h0);
        end
        for (int i = 0; i < 9; i++) begin
            axi_read(bases[i], 0, d, r);
            check("R2 region word 0 own value", d, 32'hA000_0000 + i);
            check("R2 read resp OKAY", {30'b0, r}, 32'h0);
        end
        axi_write(20'h1_4158, 32'h5555_0003, 4'hF, 0, 0, r);
        axi_read(20'h1_4158, 0, d, r);
        check("R2 interrupt window last word", d, 32'h5555_0003);
        axi_write(20'h1_41AC, 32'h6666_0003, 4'hF, 0, 0, r);
        axi_read(20'h1_41AC, 0, d, r);
        check("R2 timing window last word", d, 32'h6666_0003);
    endtask

    task automatic t_reserved();
        logic [31:0] d; logic [1:0] r;
        axi_write(20'h0_0010, 32'hFFFF_FFFF, 4'hF, 0, 0, r);
        check("R3 reserved write OKAY", {30'b0, r}, 32'h0);
        axi_read(20'h0_0010, 0, d, r);
        check("R3 reserved read zero", d, 32'h0);
        check("R3 reserved read OKAY", {30'b0, r}, 32'h0);
        axi_read(20'h0_0000, 0, d, r);
        check("R3 reserved write left word 0", d, 32'hA000_0000);
        axi_read(20'h8_3FFC, 0, d, r);
        check("R3 last word of function 3 OKAY", {30'b0, r}, 32'h0);
        check("R3 last word of function 3 zero", d, 32'h0);
        axi_read(20'h0_0BFC, 0, d, r);
        check("R3 last perf word OKAY", {30'b0, r}, 32'h0);
    endtask

    task automatic t_unmapped();
        logic [19:0] holes [5] = '{20'h0_0C00, 20'h1_4148, 20'h1_415C, 20'h8_4000, 20'h4_0000};
        logic [31:0] d; logic [1:0] r;
        for (int i = 0; i < 5; i++) begin
            axi_read(holes[i], 0, d, r);
            check("R4 unmapped read DECERR", {30'b0, r}, 32'h3);
            check("R4 unmapped read zero", d, 32'h0);
        end
        axi_write(20'h4_0000, 32'h1234_5678, 4'hF, 0, 0, r);
        check("R4 unmapped write DECERR", {30'b0, r}, 32'h3);
        axi_write(20'h1_415C, 32'h1234_5678, 4'hF, 0, 0, r);
        check("R4 gap write DECERR", {30'b0, r}, 32'h3);
        axi_read(20'h0_0000, 0, d, r);
        check("R4 unmapped write left control", d, 32'hA000_0000);
        axi_read(20'h1_4158, 0, d, r);
        check("R4 gap write left interrupt word", d, 32'h5555_0003);
    endtask

    task automatic t_ro_mask();
        logic [31:0] d; logic [1:0] r;
        status_in = 16'hBEEF;
        axi_write(20'h0_0004, 32'hFFFF_FFFF, 4'hF, 0, 0, r);
        check("R5 RO write OKAY", {30'b0, r}, 32'h0);
        axi_read(20'h0_0004, 0, d, r);
        check("R5 status word", d, 32'hBEEF_FFFF);
        status_in = 16'h1234;
        axi_read(20'h0_0004, 0, d, r);
        check("R5 status is live", d, 32'h1234_FFFF);
        axi_write(20'h0_0008, 32'hFFFF_FFFF, 4'hF, 0, 0, r);
        axi_read(20'h0_0008, 0, d, r);
        check("R5 split mask word", d, 32'h00FF_00FF);
        axi_write(20'h0_0404, 32'hFFFF_FFFF, 4'hF, 0, 0, r);
        axi_read(20'h0_0404, 0, d, r);
        check("R5 debug word 0x4 upper RO zero", d, 32'h0000_FFFF);
    endtask

    task automatic t_strb();
        logic [31:0] d; logic [1:0] r;
        axi_write(20'h0_000C, 32'h0, 4'hF, 0, 0, r);
        axi_write(20'h0_000C, 32'hAABB_CCDD, 4'b0101, 0, 0, r);
        axi_read(20'h0_000C, 0, d, r);
        check("R6 lanes 0 and 2", d, 32'h00BB_00DD);
        axi_write(20'h0_000C, 32'h1122_3344, 4'b1000, 0, 0, r);
        axi_read(20'h0_000C, 0, d, r);
        check("R6 lane 3 only", d, 32'h11BB_00DD);
    endtask

    task automatic t_order();
        logic [31:0] d; logic [1:0] r; int c0;
        c0 = bcount;
        axi_write(20'h0_0400, 32'hC0DE_0001, 4'hF, 1, 0, r);
        check("R7 one response, address first", bcount, c0 + 1);
        axi_read(20'h0_0400, 0, d, r);
        check("R7 data after address-first", d, 32'hC0DE_0001);
        c0 = bcount;
        axi_write(20'h0_0400, 32'hC0DE_0002, 4'hF, 2, 0, r);
        check("R7 one response, data first", bcount, c0 + 1);
        axi_read(20'h0_0400, 0, d, r);
        check("R7 data after data-first", d, 32'hC0DE_0002);
    endtask

    task automatic t_hold();
        logic [31:0] d; logic [1:0] r;
        axi_write(20'h8_2004, 32'h0000_7777, 4'hF, 0, 3, r);
        check("R8 held write resp OKAY", {30'b0, r}, 32'h0);
        axi_read(20'h8_2004, 3, d, r);
        check("R8 held read data", d, 32'h0000_7777);
        axi_read(20'h0_0C04, 2, d, r);
        check("R9 held DECERR", {30'b0, r}, 32'h3);
    endtask

    task automatic t_lsb();
        logic [31:0] d; logic [1:0] r;
        axi_write(20'h0_0003, 32'h0BAD_F00D, 4'hF, 0, 0, r);
        axi_read(20'h0_0002, 0, d, r);
        check("R10 low bits ignored", d, 32'h0BAD_F00D);
        axi_read(20'h1_414F, 0, d, r);
        check("R10 interrupt word 0 by odd byte", d, 32'hA000_0003);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_region_map();
        t_reserved();
        t_unmapped();
        t_ro_mask();
        t_strb();
        t_order();
        t_hold();
        t_lsb();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule